// File: doc/BRIEF.md
# Receive Byte-Pairing Gearbox

This block sits between a receive PCS datapath and a fabric interface that runs at half the PCS rate. Each accepted input word arrives with its per-lane status bits and an alignment flag. Consecutive words are paired and presented as one output word of twice the width, together with the paired status. Arrival order is fixed: the earlier word of a pair fills the least significant half, and the later word fills the upper half. The slow clock is modelled as an output-valid strobe on the fast clock, with one strobe for every two accepted words.

The data width is chosen at run time. Two single-width settings take 8-bit decoded or 10-bit undecoded words. Two double-width settings take 16-bit or 20-bit words. The alignment pattern can end up in either half after pairing, so the block reports it as two flags, one per half. Control logic can use a resynchronize input to restart pairing, which moves the pattern into the low half. When the PCS rate does not call for pairing, a bypass setting forwards each word to the low half at full rate.

Top module: `rx_gear_top`

## Requirements
- R1: With bypass low, two accepted words w1 then w2 give, in the cycle after w2 is accepted, a `dout` equal to w2 shifted left by the word width W, OR-ed with w1. `outValid` is high for exactly that one cycle.
- R2: `mode` encoding: 0 selects 8-bit words, 1 selects 10-bit, 2 selects 16-bit and 3 selects 20-bit. Input bits at or above W are ignored, and output bits at or above 2W read zero.
- R3: In pair mode `doutStat` equals {status of w2, status of w1}, each half 2 bits wide.
- R4: In pair mode `alignLo` carries the alignment flag of w1 and `alignHi` carries the flag of w2.
- R5: Cycles with `inValid` low do not advance pairing and never raise `outValid`. `outValid` is high only in the cycle after an accepted word that completes a pair, or after an accepted word in bypass.
- R6: A word accepted with `resync` high becomes the low half of a new pair, and any earlier unpaired word is discarded. No output follows that word.
- R7: With bypass high, every accepted word appears one cycle later in `dout` bits W-1:0 with all upper bits zero. Its status goes to the low status lanes and the upper lanes read zero. `alignLo` carries its flag, `alignHi` is 0 and `outValid` is high. Any half-built pair is dropped.
- R8: After reset `dout`, `doutStat`, `alignLo`, `alignHi` and `outValid` are all zero, and the next accepted word becomes a low half.
- R9: Between output strobes `dout`, `doutStat` and the alignment flags hold their last values, whatever the input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast PCS-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Word-width select (see R2) |
| bypass | input | 1 | Full-rate pass-through select |
| resync | input | 1 | Restart pairing with the current word |
| inValid | input | 1 | Input word accepted this cycle |
| din | input | 20 | Input word, LSB-aligned |
| dinStat | input | 2 | Per-lane status of the input word |
| dinAlign | input | 1 | Alignment pattern seen in the input word |
| dout | output | 40 | Paired output word |
| doutStat | output | 4 | Paired status, high lanes from the later word |
| alignLo | output | 1 | Alignment pattern in the low half |
| alignHi | output | 1 | Alignment pattern in the high half |
| outValid | output | 1 | One-cycle strobe marking a new output |

## Verification
Every result appears exactly one clock after the accepted word that produces it. A completed pair or a bypass word shows up on the outputs in the cycle that follows its acceptance. A first half or a resynchronizing word shows nothing, and `outValid` stays low in the cycle after it. The bench drives inputs on the falling edge and samples on the next falling edge, so each sample sees exactly one register update. Hold behaviour is checked over several idle cycles in which `din` keeps changing.

// File: rtl/rx_gear_pkg.sv
package rx_gear_pkg;

  typedef enum logic [1:0] {
    MODE_S8  = 2'd0,
    MODE_S10 = 2'd1,
    MODE_D16 = 2'd2,
    MODE_D20 = 2'd3
  } gearMode_e;

  typedef struct packed {
    logic capLo;
    logic emitPair;
    logic emitByp;
  } gearStb_t;

  function automatic int wordWidth(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 10;
      2'd2:    return 16;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/rx_gear_ctrl.sv
module rx_gear_ctrl
  import rx_gear_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     inValid,
  input  logic     bypass,
  input  logic     resync,
  output gearStb_t stb
);

  logic phase;
  logic effPhase;

  assign effPhase = resync ? 1'b0 : phase;

  always_comb begin
    stb = '0;
    if (inValid) begin
      if (bypass)         stb.emitByp  = 1'b1;
      else if (!effPhase) stb.capLo    = 1'b1;
      else                stb.emitPair = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
    end else if (inValid) begin
      phase <= bypass ? 1'b0 : ~effPhase;
    end else if (resync) begin
      phase <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_gear_dp.sv
module rx_gear_dp
  import rx_gear_pkg::*;
#(
  parameter int MAX_W  = 20,
  parameter int STAT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  gearStb_t              stb,
  input  logic [1:0]            mode,
  input  logic [MAX_W-1:0]      din,
  input  logic [STAT_W-1:0]     dinStat,
  input  logic                  dinAlign,
  output logic [2*MAX_W-1:0]    dout,
  output logic [2*STAT_W-1:0]   doutStat,
  output logic                  alignLo,
  output logic                  alignHi,
  output logic                  outValid
);

  localparam int OUT_W = 2 * MAX_W;
  localparam int OST_W = 2 * STAT_W;
  localparam int SH_W  = $clog2(MAX_W + 1);
  localparam logic [MAX_W:0] ONE = 1;

  logic [MAX_W-1:0]  modeMask [4];
  logic [MAX_W-1:0]  dinM;
  logic [SH_W-1:0]   shAmt;
  logic [OUT_W-1:0]  packedWord;
  logic [MAX_W-1:0]  loData;
  logic [STAT_W-1:0] loStat;
  logic              loAlign;

  for (genvar m = 0; m < 4; m++) begin : g_mask
    assign modeMask[m] = MAX_W'((ONE << wordWidth(2'(m))) - ONE);
  end

  assign dinM       = din & modeMask[mode];
  assign shAmt      = SH_W'(wordWidth(mode));
  assign packedWord = (OUT_W'(dinM) << shAmt) | OUT_W'(loData);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loData   <= '0;
      loStat   <= '0;
      loAlign  <= 1'b0;
      dout     <= '0;
      doutStat <= '0;
      alignLo  <= 1'b0;
      alignHi  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= 1'b0;
      if (stb.capLo) begin
        loData  <= dinM;
        loStat  <= dinStat;
        loAlign <= dinAlign;
      end
      if (stb.emitPair) begin
        dout     <= packedWord;
        doutStat <= {dinStat, loStat};
        alignLo  <= loAlign;
        alignHi  <= dinAlign;
        outValid <= 1'b1;
      end
      if (stb.emitByp) begin
        dout     <= OUT_W'(dinM);
        doutStat <= OST_W'(dinStat);
        alignLo  <= dinAlign;
        alignHi  <= 1'b0;
        outValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_gear_top.sv
module rx_gear_top
  import rx_gear_pkg::*;
#(
  parameter int MAX_W  = 20,
  parameter int STAT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                bypass,
  input  logic                resync,
  input  logic                inValid,
  input  logic [MAX_W-1:0]    din,
  input  logic [STAT_W-1:0]   dinStat,
  input  logic                dinAlign,
  output logic [2*MAX_W-1:0]  dout,
  output logic [2*STAT_W-1:0] doutStat,
  output logic                alignLo,
  output logic                alignHi,
  output logic                outValid
);

  gearStb_t stb;

  rx_gear_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .bypass  (bypass),
    .resync  (resync),
    .stb     (stb)
  );

  rx_gear_dp #(.MAX_W(MAX_W), .STAT_W(STAT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .mode     (mode),
    .din      (din),
    .dinStat  (dinStat),
    .dinAlign (dinAlign),
    .dout     (dout),
    .doutStat (doutStat),
    .alignLo  (alignLo),
    .alignHi  (alignHi),
    .outValid (outValid)
  );

endmodule

// File: rtl/rx_gear_chk.sv
module rx_gear_chk #(
  parameter int MAX_W  = 20,
  parameter int STAT_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode,
  input logic                bypass,
  input logic                resync,
  input logic                inValid,
  input logic [2*MAX_W-1:0]  dout,
  input logic [2*STAT_W-1:0] doutStat,
  input logic                alignHi,
  input logic                outValid
);

  AST_NO_BACK_TO_BACK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !bypass) |=> !outValid); // R1

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid); // R5

  AST_RESYNC_STARTS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && resync && !bypass) |=> !outValid); // R6

  AST_BYPASS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && bypass) |=> outValid); // R7

  AST_BYPASS_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && bypass) |=> (!alignHi && doutStat[2*STAT_W-1:STAT_W] == '0)); // R7

  AST_S8_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && mode == 2'd0 && $past(mode) == 2'd0) |-> dout[2*MAX_W-1:16] == '0); // R2

endmodule

bind rx_gear_top rx_gear_chk #(.MAX_W(MAX_W), .STAT_W(STAT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .bypass   (bypass),
  .resync   (resync),
  .inValid  (inValid),
  .dout     (dout),
  .doutStat (doutStat),
  .alignHi  (alignHi),
  .outValid (outValid)
);

// File: tb/rx_gear_top_test.sv
module rx_gear_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        bypass = 1'b0;
  logic        resync = 1'b0;
  logic        inValid = 1'b0;
  logic [19:0] din = '0;
  logic [1:0]  dinStat = '0;
  logic        dinAlign = 1'b0;
  logic [39:0] dout;
  logic [3:0]  doutStat;
  logic        alignLo;
  logic        alignHi;
  logic        outValid;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  rx_gear_top uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bypass(bypass), .resync(resync),
    .inValid(inValid), .din(din), .dinStat(dinStat), .dinAlign(dinAlign),
    .dout(dout), .doutStat(doutStat), .alignLo(alignLo), .alignHi(alignHi),
    .outValid(outValid)
  );

  function automatic int widthOf(input logic [1:0] m);
    case (m)
      2'd0: return 8;
      2'd1: return 10;
      2'd2: return 16;
      default: return 20;
    endcase
  endfunction

  function automatic logic [39:0] expPair(input logic [1:0] m, input logic [19:0] w1, input logic [19:0] w2);
    logic [39:0] msk;
    msk = (40'd1 << widthOf(m)) - 40'd1;
    return (((40'(w2)) & msk) << widthOf(m)) | ((40'(w1)) & msk);
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [19:0] d, input logic [1:0] s, input logic a, input logic r);
    @(negedge clk);
    inValid = 1'b1; din = d; dinStat = s; dinAlign = a; resync = r;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; resync = 1'b0; din = din ^ 20'h5A5A5; dinStat = ~dinStat; dinAlign = ~dinAlign;
  endtask

  task automatic testReset();
    check("R8", "dout", 64'(dout), 64'd0);
    check("R8", "doutStat", 64'(doutStat), 64'd0);
    check("R8", "align flags", 64'({alignHi, alignLo}), 64'd0);
    check("R8", "outValid", 64'(outValid), 64'd0);
  endtask

  task automatic testPair(input logic [1:0] m, input logic [19:0] w1, input logic [19:0] w2,
                          input logic [1:0] s1, input logic [1:0] s2, input logic a1, input logic a2);
    @(negedge clk); mode = m;
    drive(w1, s1, a1, 1'b0);
    drive(w2, s2, a2, 1'b0);
    idle();
    check("R1", "pair valid", 64'(outValid), 64'd1);
    check("R2", "paired data", 64'(dout), 64'(expPair(m, w1, w2)));
    check("R3", "paired status", 64'(doutStat), 64'({s2, s1}));
    check("R4", "align lo/hi", 64'({alignHi, alignLo}), 64'({a2, a1}));
    idle();
    check("R1", "single-cycle strobe", 64'(outValid), 64'd0);
  endtask

  task automatic testGapAndHold();
    @(negedge clk); mode = 2'd1;
    drive(20'h0012A, 2'b01, 1'b0, 1'b0);
    idle();
    check("R5", "no strobe after half", 64'(outValid), 64'd0);
    idle();
    check("R5", "no strobe while idle", 64'(outValid), 64'd0);
    drive(20'h00355, 2'b10, 1'b1, 1'b0);
    idle();
    check("R5", "gap pair valid", 64'(outValid), 64'd1);
    check("R5", "gap pair data", 64'(dout), 64'(expPair(2'd1, 20'h0012A, 20'h00355)));
    for (int i = 0; i < 4; i++) begin
      idle();
      check("R9", "held data", 64'(dout), 64'(expPair(2'd1, 20'h0012A, 20'h00355)));
      check("R9", "held status/flags", 64'({doutStat, alignHi, alignLo}), 64'({4'b1001, 1'b1, 1'b0}));
    end
  endtask

  task automatic testResync();
    @(negedge clk); mode = 2'd2;
    drive(20'h01111, 2'b00, 1'b0, 1'b0);
    drive(20'h02222, 2'b11, 1'b1, 1'b1);
    idle();
    check("R6", "no strobe after resync word", 64'(outValid), 64'd0);
    drive(20'h03333, 2'b01, 1'b0, 1'b0);
    idle();
    check("R6", "resync pair valid", 64'(outValid), 64'd1);
    check("R6", "resync pair data", 64'(dout), 64'(expPair(2'd2, 20'h02222, 20'h03333)));
    check("R6", "alignment in low half", 64'({alignHi, alignLo}), 64'b01);
  endtask

  task automatic testBypass();
    @(negedge clk); mode = 2'd3;
    drive(20'hABCDE, 2'b10, 1'b0, 1'b0);
    @(negedge clk); bypass = 1'b1;
    inValid = 1'b1; din = 20'hFEDCB; dinStat = 2'b11; dinAlign = 1'b1;
    @(negedge clk); din = 20'h13579; dinStat = 2'b01; dinAlign = 1'b0;
    check("R7", "bypass valid", 64'(outValid), 64'd1);
    check("R7", "bypass data", 64'(dout), 64'h00000FEDCB);
    check("R7", "bypass status", 64'(doutStat), 64'b0011);
    check("R7", "bypass flags", 64'({alignHi, alignLo}), 64'b01);
    @(negedge clk); inValid = 1'b0; bypass = 1'b0; mode = 2'd0; din = 20'hFFF77;
    check("R7", "back-to-back bypass valid", 64'(outValid), 64'd1);
    check("R7", "back-to-back bypass data", 64'(dout), 64'h0000013579);
    drive(20'hFFF44, 2'b00, 1'b0, 1'b0);
    drive(20'hFFF88, 2'b00, 1'b0, 1'b0);
    idle();
    check("R7", "pairing restarts after bypass", 64'(dout), 64'h0000008844);
    check("R2", "upper bits zero in 8-bit mode", 64'(dout[39:16]), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testPair(2'd0, 20'hFFF3C, 20'hAAAC3, 2'b01, 2'b10, 1'b0, 1'b1);
    testPair(2'd1, 20'hFF2A5, 20'h0015A, 2'b11, 2'b00, 1'b1, 1'b0);
    testPair(2'd2, 20'hF1234, 20'h0BEEF, 2'b10, 2'b01, 1'b0, 1'b0);
    testPair(2'd3, 20'hCAFE1, 20'h5EED2, 2'b00, 2'b11, 1'b1, 1'b1);
    testGapAndHold();
    testResync();
    testBypass();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule